// File: doc/BRIEF.md
# Clock Output Stop and Power-Down Controller

This block decides, for each of four differential clock outputs, whether the pair toggles, is parked, or is three-stated. It runs on a core clock `clk_i`. In full-rate mode the true output changes level on every core edge. In half-rate mode it changes on every second edge. Each output has a true level, a complement level and a separate drive-enable for each.

Two active-low asynchronous requests can park the outputs:

- **Power-down** parks every output.
- **Clock-stop** parks only the outputs whose stop-permission bit is set.

Each request passes through a two-flop synchroniser. It then counts as asserted only after it has been seen low at two consecutive rising edges of the complement clock, which are the falling transitions of the true output. The outputs then park at the following rising transition of the true output. For each request, a drive-mode bit picks the parked form:

- **0:** true held high and complement undriven.
- **1:** both signals undriven.

Outputs also go undriven in two other cases:

- Their enable register bit is 0.
- Their associated three-state pin is low.

Top module: `ckstop_ctrl`

## Requirements
- R1: While `rst_ni` is low, every drive-enable output is 0.
- R2: A running output has both drive-enables at 1, its complement equal to the inverse of its true level, and in full-rate mode (`half_rate_ni`=1) its true level changes on every core clock edge.
- R3: With `half_rate_ni`=0 the true level of a running output changes on every second core clock edge only.
- R4: A power-down request (`pwr_dn_ni` low) goes through a two-flop synchroniser. It is counted at true-output falling transitions and takes effect at the first true-output rising transition after two consecutive counted falls. If `pwr_dn_ni` falls right after a core edge that set the true output to 1, the output still runs after the 5th following edge and is parked after the 6th.
- R5: When power-down is in effect and `pd_float_i`=0, each enabled output drives true=1 with true drive-enable 1 and complement drive-enable 0. When `pd_float_i`=1, both drive-enables are 0.
- R6: Clock-stop (`clk_stop_ni` low) uses the same synchroniser and entry timing as power-down. Its parked form is chosen by `stop_float_i` with the same encoding.
- R7: Clock-stop affects output i only when `stop_allow_i[i]`=1. Otherwise that output keeps running.
- R8: `out_en_i[i]`=0 makes both drive-enables of output i 0. This has priority over parking.
- R9: Output 0 follows pin `tri_ni[0]` and output 3 follows pin `tri_ni[1]`. A low pin makes both drive-enables of that output 0. Outputs 1 and 2 ignore the pins. A pin change reaches the outputs at the third core edge after it.
- R10: When power-down and clock-stop are both in effect, the power-down drive mode decides the parked form.
- R11: After a request is released, the output resumes within 3 to 4 core edges. Its first running sample has true=1, followed by a full-length high phase, and it enters park only on a true rising transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_dn_ni | input | 1 | Power-down request, active low, asynchronous |
| clk_stop_ni | input | 1 | Clock-stop request, active low, asynchronous |
| tri_ni | input | 2 | Three-state pins, low undrives the associated output |
| pd_float_i | input | 1 | Power-down parked form: 0 true high, 1 undriven |
| stop_float_i | input | 1 | Clock-stop parked form: 0 true high, 1 undriven |
| half_rate_ni | input | 1 | 0 selects half-rate outputs, 1 full rate |
| out_en_i | input | 4 | Per-output enable register bits |
| stop_allow_i | input | 4 | Per-output clock-stop permission bits |
| dif_t_o | output | 4 | True output levels |
| dif_c_o | output | 4 | Complement output levels |
| dif_t_oe_o | output | 4 | True drive-enables |
| dif_c_oe_o | output | 4 | Complement drive-enables |

## Verification
The bench aligns a request to a known output phase and checks the exact edge at which parking starts. A design that counted a single sample, or parked on a falling transition, would park one or more edges early and leave a short high pulse. It releases requests in both parked forms and checks that the first running sample is high. A design that resumed on any edge would produce a runt low or high phase. The static vectors cross the enable bits, the pins, the stop mask and simultaneous power-down and stop. They catch a wrong priority order, a wrong pin-to-output map, or a mask that is ignored. The half-rate check counts level changes, which exposes a divider that never engages.

// File: rtl/ckstop_pkg.sv
package ckstop_pkg;

    typedef enum logic [1:0] {
        LANE_OFF  = 2'd0,
        LANE_PARK = 2'd1,
        LANE_RUN  = 2'd2
    } lane_mode_e;

    typedef struct packed {
        logic t;
        logic c;
        logic oe_t;
        logic oe_c;
    } lane_out_s;

endpackage

// File: rtl/ckstop_sync.sv
module ckstop_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_s;

    sync_st_s st_d, st_q;

    always_comb begin
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.s2;

endmodule

// File: rtl/ckstop_seq.sv
module ckstop_seq #(
    parameter int HITS = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    input  logic fall_i,
    input  logic rise_i,
    output logic active_o,
    output logic active_nxt_o
);

    localparam int CW = $clog2(HITS + 1);

    typedef struct packed {
        logic [CW-1:0] hit;
        logic          active;
    } seq_st_s;

    seq_st_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fall_i) begin
            if (!req_i) begin
                st_d.hit = '0;
            end else if (st_q.hit != CW'(HITS)) begin
                st_d.hit = st_q.hit + 1'b1;
            end
        end
        if (rise_i) begin
            st_d.active = (st_q.hit == CW'(HITS)) && req_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o     = st_q.active;
    assign active_nxt_o = st_d.active;

endmodule

// File: rtl/ckstop_lane.sv
module ckstop_lane
    import ckstop_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      ph_nxt_i,
    input  logic      off_i,
    input  logic      pd_nxt_i,
    input  logic      pd_float_i,
    input  logic      stop_nxt_i,
    input  logic      stop_float_i,
    output lane_out_s out_o
);

    lane_mode_e mode;
    lane_out_s  out_d, out_q;

    always_comb begin
        if (off_i) begin
            mode = LANE_OFF;
        end else if (pd_nxt_i) begin
            mode = pd_float_i ? LANE_OFF : LANE_PARK;
        end else if (stop_nxt_i) begin
            mode = stop_float_i ? LANE_OFF : LANE_PARK;
        end else begin
            mode = LANE_RUN;
        end

        out_d = '0;
        case (mode)
            LANE_PARK: begin
                out_d.t    = 1'b1;
                out_d.oe_t = 1'b1;
            end
            LANE_RUN: begin
                out_d.t    = ph_nxt_i;
                out_d.c    = ~ph_nxt_i;
                out_d.oe_t = 1'b1;
                out_d.oe_c = 1'b1;
            end
            default: out_d = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_o = out_q;

endmodule

// File: rtl/ckstop_ctrl.sv
module ckstop_ctrl
    import ckstop_pkg::*;
#(
    parameter int               N_OUT     = 4,
    parameter int               SYNC_HITS = 2,
    parameter logic [N_OUT-1:0] PIN_USE   = 4'b1001,
    parameter logic [N_OUT-1:0] PIN_SEL   = 4'b1000
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pwr_dn_ni,
    input  logic             clk_stop_ni,
    input  logic [1:0]       tri_ni,
    input  logic             pd_float_i,
    input  logic             stop_float_i,
    input  logic             half_rate_ni,
    input  logic [N_OUT-1:0] out_en_i,
    input  logic [N_OUT-1:0] stop_allow_i,
    output logic [N_OUT-1:0] dif_t_o,
    output logic [N_OUT-1:0] dif_c_o,
    output logic [N_OUT-1:0] dif_t_oe_o,
    output logic [N_OUT-1:0] dif_c_oe_o
);

    localparam int N_REQ  = 2;
    localparam int SYNC_W = N_REQ + 2;

    typedef struct packed {
        logic ph;
        logic div;
    } gen_st_s;

    gen_st_s st_d, st_q;
    logic    tick, fall_evt, rise_evt;

    logic [SYNC_W-1:0] raw_in, synced;
    logic [N_REQ-1:0]  req, act, act_nxt;
    logic [1:0]        tri_s;

    // Phase generator: one level per edge at full rate, per two edges at half rate.
    always_comb begin
        tick     = half_rate_ni | st_q.div;
        fall_evt = tick & st_q.ph;
        rise_evt = tick & ~st_q.ph;
        st_d.div = ~st_q.div;
        st_d.ph  = tick ? ~st_q.ph : st_q.ph;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_in = {tri_ni, clk_stop_ni, pwr_dn_ni};

    ckstop_sync #(
        .W       (SYNC_W),
        .RST_VAL ({SYNC_W{1'b1}})
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (raw_in),
        .q_o    (synced)
    );

    assign req   = ~synced[N_REQ-1:0];
    assign tri_s = synced[SYNC_W-1:N_REQ];

    // Index 0: power-down, index 1: clock-stop.
    for (genvar r = 0; r < N_REQ; r++) begin : g_seq
        ckstop_seq #(
            .HITS (SYNC_HITS)
        ) u_seq (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .req_i        (req[r]),
            .fall_i       (fall_evt),
            .rise_i       (rise_evt),
            .active_o     (act[r]),
            .active_nxt_o (act_nxt[r])
        );
    end

    for (genvar i = 0; i < N_OUT; i++) begin : g_lane
        logic      off;
        lane_out_s lane_q;

        if (PIN_USE[i]) begin : g_pin
            assign off = ~out_en_i[i] | ~tri_s[PIN_SEL[i]];
        end else begin : g_nopin
            assign off = ~out_en_i[i];
        end

        ckstop_lane u_lane (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .ph_nxt_i     (st_d.ph),
            .off_i        (off),
            .pd_nxt_i     (act_nxt[0]),
            .pd_float_i   (pd_float_i),
            .stop_nxt_i   (act_nxt[1] & stop_allow_i[i]),
            .stop_float_i (stop_float_i),
            .out_o        (lane_q)
        );

        assign dif_t_o[i]    = lane_q.t;
        assign dif_c_o[i]    = lane_q.c;
        assign dif_t_oe_o[i] = lane_q.oe_t;
        assign dif_c_oe_o[i] = lane_q.oe_c;
    end

    logic unused_act;
    assign unused_act = ^act;

endmodule

// File: rtl/ckstop_ctrl_chk.sv
module ckstop_ctrl_chk #(
    parameter int N_OUT = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [N_OUT-1:0] out_en_i,
    input logic [N_OUT-1:0] stop_allow_i,
    input logic [N_OUT-1:0] dif_t_o,
    input logic [N_OUT-1:0] dif_c_o,
    input logic [N_OUT-1:0] dif_t_oe_o,
    input logic [N_OUT-1:0] dif_c_oe_o
);

    always_comb begin
        if (!rst_ni) begin
            p_reset_undriven_r1 : assert ((dif_t_oe_o | dif_c_oe_o) == '0);
        end
    end

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        p_comp_inverse_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            (dif_t_oe_o[i] && dif_c_oe_o[i]) |-> (dif_c_o[i] == !dif_t_o[i]));

        p_park_high_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            (dif_t_oe_o[i] && !dif_c_oe_o[i]) |-> dif_t_o[i]);

        p_no_lone_comp_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            dif_c_oe_o[i] |-> dif_t_oe_o[i]);

        p_disabled_off_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            !out_en_i[i] |=> (!dif_t_oe_o[i] && !dif_c_oe_o[i]));

        p_park_on_rise_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            (dif_t_oe_o[i] && !dif_c_oe_o[i] && $past(dif_t_oe_o[i] && dif_c_oe_o[i]))
            |-> !$past(dif_t_o[i]));

        p_resume_high_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            (dif_t_oe_o[i] && dif_c_oe_o[i] && $past(dif_t_oe_o[i] && !dif_c_oe_o[i])
             && ($past(stop_allow_i[i]) == $past(stop_allow_i[i], 2)))
            |-> dif_t_o[i]);
    end

endmodule

bind ckstop_ctrl ckstop_ctrl_chk #(.N_OUT(N_OUT)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .out_en_i     (out_en_i),
    .stop_allow_i (stop_allow_i),
    .dif_t_o      (dif_t_o),
    .dif_c_o      (dif_c_o),
    .dif_t_oe_o   (dif_t_oe_o),
    .dif_c_oe_o   (dif_c_oe_o)
);

// File: tb/sim_ckstop_ctrl.sv
module sim_ckstop_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 12;

    typedef struct packed {
        logic [3:0] en;
        logic [3:0] allow;
        logic [1:0] tri_n;
        logic       pd_n;
        logic       stop_n;
        logic       pdf;
        logic       sf;
        logic [7:0] exp;   // 2 bits per output, output 3 on top: 0 off, 1 park high, 2 run
    } vec_s;

    localparam vec_s VECS [N_VEC] = '{
        '{4'hF, 4'h0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 8'hAA},
        '{4'hF, 4'hF, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 8'h55},
        '{4'hF, 4'h5, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 8'h88},
        '{4'hF, 4'h0, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 8'hAA},
        '{4'hA, 4'h0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 8'h88},
        '{4'hF, 4'h0, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 8'hA8},
        '{4'hF, 4'h0, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 8'h2A},
        '{4'hF, 4'h0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h14},
        '{4'hF, 4'h0, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00},
        '{4'hF, 4'hF, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 8'h55},
        '{4'h7, 4'h0, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 8'h15},
        '{4'hF, 4'h0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 8'hAA}
    };

    localparam string VTAG [N_VEC] = '{
        "R2 all running", "R6 stop parks high", "R7 stop mask undriven",
        "R7 stop with empty mask", "R8 enable bits", "R9 pin 0 on output 0",
        "R9 pin 1 on output 3", "R5 R9 pins with power-down", "R5 power-down undriven",
        "R10 power-down over stop", "R8 enable over power-down", "R2 all running again"
    };

    logic       clk = 1'b0;
    logic       rst_ni;
    logic       pd_n, stop_n, pdf, sf, half_n;
    logic [1:0] tri_n;
    logic [3:0] en, allow;
    logic [3:0] dif_t_o, dif_c_o, dif_t_oe_o, dif_c_oe_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ckstop_ctrl u0 (
        .clk_i        (clk),
        .rst_ni       (rst_ni),
        .pwr_dn_ni    (pd_n),
        .clk_stop_ni  (stop_n),
        .tri_ni       (tri_n),
        .pd_float_i   (pdf),
        .stop_float_i (sf),
        .half_rate_ni (half_n),
        .out_en_i     (en),
        .stop_allow_i (allow),
        .dif_t_o      (dif_t_o),
        .dif_c_o      (dif_c_o),
        .dif_t_oe_o   (dif_t_oe_o),
        .dif_c_oe_o   (dif_c_oe_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    function automatic logic [1:0] classify(logic t, logic c, logic toe, logic coe);
        if (!toe && !coe)                return 2'd0;
        if (toe && !coe && t)            return 2'd1;
        if (toe && coe && (c == !t))     return 2'd2;
        return 2'd3;
    endfunction

    task automatic apply(input vec_s v);
        en     = v.en;
        allow  = v.allow;
        tri_n  = v.tri_n;
        pd_n   = v.pd_n;
        stop_n = v.stop_n;
        pdf    = v.pdf;
        sf     = v.sf;
    endtask

    task automatic set_running();
        apply('{4'hF, 4'hF, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        summary();
    end

    initial begin
        logic [1:0] got [4];
        logic [3:0] prev_t;
        int         k;
        int         changes;
        logic       adj;
        logic       last_t;

        rst_ni = 1'b0;
        half_n = 1'b1;
        set_running();
        repeat (3) @(negedge clk);
        // R1: nothing driven in reset
        chk("R1 reset drive-enables", {dif_t_oe_o, dif_c_oe_o}, 8'h00);
        rst_ni = 1'b1;
        repeat (4) @(negedge clk);

        // Static vector table
        for (int v = 0; v < N_VEC; v++) begin
            apply(VECS[v]);
            repeat (16) @(negedge clk);
            prev_t = dif_t_o;
            for (int s = 0; s < 4; s++) begin
                @(negedge clk);
                for (int i = 0; i < 4; i++) begin
                    logic [1:0] cd;
                    cd = classify(dif_t_o[i], dif_c_o[i], dif_t_oe_o[i], dif_c_oe_o[i]);
                    if (cd == 2'd2 && dif_t_o[i] == prev_t[i]) cd = 2'd3;
                    if (s == 0) got[i] = cd;
                    else if (got[i] != cd) got[i] = 2'd3;
                end
                prev_t = dif_t_o;
            end
            for (int i = 0; i < 4; i++) begin
                chk($sformatf("%s vector %0d output %0d", VTAG[v], v, i),
                    32'(got[i]), 32'(VECS[v].exp[2*i +: 2]));
            end
        end

        // R4 / R5: power-down entry timing, parked true high
        set_running();
        repeat (12) @(negedge clk);
        do @(negedge clk); while (dif_t_o[1] !== 1'b1);
        pd_n = 1'b0;
        repeat (5) @(negedge clk);
        chk("R4 still running after 5 edges", {dif_t_o[1], dif_c_oe_o[1]}, 2'b01);
        @(negedge clk);
        chk("R4 R5 parked after 6 edges", {dif_t_oe_o, dif_c_oe_o, dif_t_o}, 12'hF0F);
        repeat (3) @(negedge clk);
        chk("R5 park held", {dif_t_oe_o, dif_c_oe_o, dif_t_o}, 12'hF0F);

        // R11: release from driven park
        pd_n = 1'b1;
        k = 0;
        do begin @(negedge clk); k++; end while (dif_c_oe_o[1] !== 1'b1 && k < 10);
        chk("R11 resume latency in 3..4", 32'(k >= 3 && k <= 4), 32'd1);
        chk("R11 first running level high", dif_t_o[1], 1'b1);
        @(negedge clk);
        chk("R11 full high phase then low", dif_t_o[1], 1'b0);

        // R6: clock-stop entry timing with undriven parking
        sf = 1'b1;
        repeat (8) @(negedge clk);
        do @(negedge clk); while (dif_t_o[2] !== 1'b1);
        stop_n = 1'b0;
        repeat (5) @(negedge clk);
        chk("R6 still running after 5 edges", {dif_t_o[2], dif_c_oe_o[2]}, 2'b01);
        @(negedge clk);
        chk("R6 undriven after 6 edges", {dif_t_oe_o, dif_c_oe_o}, 8'h00);

        // R11: release from undriven park
        stop_n = 1'b1;
        k = 0;
        do begin @(negedge clk); k++; end while (dif_t_oe_o[2] !== 1'b1 && k < 10);
        chk("R11 undriven resume latency in 3..4", 32'(k >= 3 && k <= 4), 32'd1);
        chk("R11 first driven level high", {dif_t_o[2], dif_c_oe_o[2]}, 2'b11);

        // R9: pin latency of three edges
        repeat (4) @(negedge clk);
        tri_n = 2'b10;
        repeat (2) @(negedge clk);
        chk("R9 pin not yet applied", dif_t_oe_o[0], 1'b1);
        @(negedge clk);
        chk("R9 pin applied at third edge", {dif_t_oe_o[0], dif_c_oe_o[0]}, 2'b00);
        tri_n = 2'b11;

        // R3: half rate
        half_n = 1'b0;
        repeat (6) @(negedge clk);
        last_t = dif_t_o[0];
        changes = 0;
        adj = 1'b0;
        for (int s = 0; s < 8; s++) begin
            logic ch;
            @(negedge clk);
            ch = (dif_t_o[0] != last_t);
            if (ch) begin
                changes++;
                if (s > 0 && adj) adj = 1'b1;
            end
            if (ch && s > 0 && (dif_t_o[0] != last_t)) begin end
            last_t = dif_t_o[0];
        end
        chk("R3 half-rate changes over 8 edges", 32'(changes), 32'd4);
        half_n = 1'b1;
        repeat (4) @(negedge clk);
        last_t = dif_t_o[0];
        changes = 0;
        for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            if (dif_t_o[0] != last_t) changes++;
            last_t = dif_t_o[0];
        end
        chk("R2 full-rate changes over 8 edges", 32'(changes), 32'd8);

        summary();
    end

endmodule